// File: doc/BRIEF.md
# Twelve-Operation Integer ALU

This block is a purely combinational integer arithmetic logic unit for a processor datapath. Each cycle the datapath presents two operands and a four-bit operation code, and the block returns one result word with no internal state and no latency.

The operations are:

- wrapping addition and subtraction
- bitwise AND, OR and XOR
- signed and unsigned less-than tests, giving a 0/1 word
- left logical, right logical and right arithmetic shifts
- a pass-through of the second operand
- a defined all-zero result for any unused code

The data width is a parameter, and the shift amount is taken from the low log2(width) bits of the second operand.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) gives opa + opb modulo 2^WIDTH.
- R2: Code 1 (subtract) gives opa − opb modulo 2^WIDTH.
- R3: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of opa and opb.
- R4: Code 5 gives 1 when opa < opb as two's-complement numbers and 0 otherwise, with every upper bit zero.
- R5: Code 6 gives 1 when opa < opb as unsigned numbers and 0 otherwise, with every upper bit zero.
- R6: Code 7 shifts opa left by opb[4:0] and fills with zeros.
- R7: Code 8 shifts opa right by opb[4:0] and fills with copies of opa[31].
- R8: Code 9 shifts opa right by opb[4:0] and fills with zeros.
- R9: Code 10 gives opb unchanged.
- R10: Codes 11 through 15 give an all-zero result.
- R11: For codes 7, 8 and 9, opb bits 31 down to 5 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation select code |
| opa | input | 32 | First operand (value to be shifted) |
| opb | input | 32 | Second operand (shift amount in low 5 bits) |
| result | output | 32 | Combinational result |

## Verification
The bench builds the block with its default width of 32, so the shift-amount field is five bits wide. This lets the bench reach every shift distance from 0 to 31 and the extreme operand values 0x80000000 and 0x7FFFFFFF, which are where signed and unsigned comparison disagree. Each operation code, including all five unused codes, is checked against a behavioural model. Each code gets directed corner operands and random operands. For the shift codes, random upper bits are placed in opb.

// File: rtl/int_alu_pkg.sv
// Package: operation codes shared by the ALU and its users.
// Assumes a 4-bit code field; codes 11..15 are unused.
package int_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_SRL  = 4'd9,
        OP_PASSB = 4'd10
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder: computes a + b, or a - b when sub is high, by inverting b
// and injecting a carry. Assumes wrap-around modulo 2^WIDTH is wanted.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic             sub,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] b_eff;

    // One adder serves both operations via conditional inversion.
    always_comb begin
        b_eff = b ^ {WIDTH{sub}};
        sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
    end

    // Undoing the operation must recover the first operand (R1, R2).
    always_comb begin
        if (!sub) p_add_inverse_r1: assert (sum - b == a) else $error("add inverse");
        if (sub)  p_sub_inverse_r2: assert (sum + b == a) else $error("sub inverse");
    end
endmodule

// File: rtl/alu_compare.sv
// Magnitude comparator: gives signed and unsigned less-than of a and b.
// Assumes two's-complement operands for the signed result.
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             lt_s,
    output logic             lt_u
);
    // Unsigned test, then signed test by flipping sign bits.
    always_comb begin
        lt_u = (a < b);
        lt_s = ({~a[WIDTH-1], a[WIDTH-2:0]} < {~b[WIDTH-1], b[WIDTH-2:0]});
    end

    // Equal operands are never less; opposite signs flip the order (R4, R5).
    always_comb begin
        if (a == b) p_eq_not_less_r4: assert (!lt_s && !lt_u) else $error("eq less");
        if (a[WIDTH-1] != b[WIDTH-1])
            p_sign_flip_r5: assert (lt_s == !lt_u) else $error("sign flip");
    end
endmodule

// File: rtl/alu_shifter.sv
// Barrel shifter: gives left logical, right logical and right arithmetic
// shifts of a by shamt. Assumes shamt is already cut to log2(WIDTH) bits.
module alu_shifter #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] shl,
    output logic [WIDTH-1:0] shr,
    output logic [WIDTH-1:0] sha
);
    logic [WIDTH-1:0] stg_l [SHW+1];
    logic [WIDTH-1:0] stg_r [SHW+1];
    logic [WIDTH-1:0] stg_a [SHW+1];

    assign stg_l[0] = a;
    assign stg_r[0] = a;
    assign stg_a[0] = a;

    // Each stage conditionally shifts by a power of two.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        always_comb begin
            stg_l[s+1] = shamt[s] ? {stg_l[s][WIDTH-1-D:0], {D{1'b0}}} : stg_l[s];
            stg_r[s+1] = shamt[s] ? {{D{1'b0}}, stg_r[s][WIDTH-1:D]} : stg_r[s];
            stg_a[s+1] = shamt[s] ? {{D{a[WIDTH-1]}}, stg_a[s][WIDTH-1:D]} : stg_a[s];
        end
    end

    assign shl = stg_l[SHW];
    assign shr = stg_r[SHW];
    assign sha = stg_a[SHW];

    // Arithmetic shift keeps the sign; it matches logical shift on positives (R7, R8).
    always_comb begin
        p_sra_sign_r7: assert (sha[WIDTH-1] == a[WIDTH-1]) else $error("sra sign");
        if (!a[WIDTH-1]) p_sra_pos_r8: assert (sha == shr) else $error("sra pos");
        if (shamt == '0) p_zero_shift_r6: assert (shl == a && shr == a) else $error("zero shift");
    end
endmodule

// File: rtl/int_alu.sv
// Top: integer ALU with twelve operations selected by a 4-bit code.
// Purely combinational; unused codes give zero. Assumes WIDTH is a power of two.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] sum, shl, shr, sha;
    logic             lt_s, lt_u, is_sub;

    assign is_sub = (op == OP_SUB);

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .sub(is_sub), .a(opa), .b(opb), .sum(sum)
    );

    alu_compare #(.WIDTH(WIDTH)) i_compare (
        .a(opa), .b(opb), .lt_s(lt_s), .lt_u(lt_u)
    );

    alu_shifter #(.WIDTH(WIDTH)) i_shifter (
        .a(opa), .shamt(opb[SHW-1:0]), .shl(shl), .shr(shr), .sha(sha)
    );

    // Result select by operation code.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB: result = sum;
            OP_AND:   result = opa & opb;
            OP_OR:    result = opa | opb;
            OP_XOR:   result = opa ^ opb;
            OP_SLT:   result = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU:  result = {{(WIDTH-1){1'b0}}, lt_u};
            OP_SLL:   result = shl;
            OP_SRA:   result = sha;
            OP_SRL:   result = shr;
            OP_PASSB: result = opb;
            default:  result = '0;
        endcase
    end

    // Compare results are 0/1 words; unused codes are zero (R4, R10).
    always_comb begin
        if (op == OP_SLT || op == OP_SLTU)
            p_cmp_narrow_r4: assert (result[WIDTH-1:1] == '0) else $error("cmp width");
        if (op > OP_PASSB)
            p_unused_zero_r10: assert (result == '0) else $error("unused code");
    end
endmodule

// File: tb/test_int_alu.sv
// Bench: behavioural reference compared every clock over directed and random stimulus.
module test_int_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    int_alu i_int_alu (.op(op), .opa(opa), .opb(opb), .result(result));

    function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        int sh = int'(y[4:0]);
        case (o)
            4'd0: return x + y;
            4'd1: return x - y;
            4'd2: return x & y;
            4'd3: return x | y;
            4'd4: return x ^ y;
            4'd5: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            4'd6: return (x < y) ? 32'd1 : 32'd0;
            4'd7: return x << sh;
            4'd8: return $unsigned($signed(x) >>> sh);
            4'd9: return x >> sh;
            4'd10: return y;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1"; 4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4"; 4'd6: return "R5"; 4'd7: return "R6";
            4'd8: return "R7"; 4'd9: return "R8"; 4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drive on the falling edge, check after the rising edge.
    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string req);
        logic [31:0] exp;
        @(negedge clk);
        op = o; opa = x; opb = y;
        exp = model(o, x, y);
        @(posedge clk);
        #1;
        n_chk++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, o, x, y, result, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give zero (R1).
        apply(4'd0, 32'h0, 32'h0, "R1");
        apply(4'd0, 32'hFFFF_FFFF, 32'h1, "R1");
        apply(4'd1, 32'h0, 32'h1, "R2");
        apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        apply(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
        apply(4'd5, 32'hFFFF_FFFF, 32'h0, "R4");
        apply(4'd6, 32'h0, 32'hFFFF_FFFF, "R5");
        for (int s = 0; s < 32; s++) begin
            apply(4'd7, 32'h8000_0001, s, "R6");
            apply(4'd8, 32'h8000_0001, s, "R7");
            apply(4'd9, 32'h8000_0001, s, "R8");
        end
        // R11: upper shift-amount bits ignored.
        apply(4'd7, 32'hF0F0_1234, 32'hFFFF_FFE3, "R11");
        apply(4'd8, 32'hF0F0_1234, 32'h8000_0024, "R11");
        apply(4'd9, 32'hF0F0_1234, 32'h7FFF_FFE0, "R11");
        apply(4'd10, 32'hAAAA_AAAA, 32'h5555_1234, "R9");
        for (int o = 11; o < 16; o++) apply(o[3:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(o[3:0], corners[i], corners[j], tag(o[3:0]));
        for (int o = 0; o < 16; o++)
            for (int k = 0; k < 150; k++)
                apply(o[3:0], $urandom, $urandom, (o >= 7 && o <= 9) ? "R11" : tag(o[3:0]));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule